// File: doc/BRIEF.md
# Memory Test Pattern Engine

This block sits in front of a memory controller and checks a region of memory on its own. Software sets a data pattern, an address ordering, a region size as a power of two, a start address and a transfer count, and then pulses start. The engine writes one word to each address of the region, then reads the same addresses back. It compares every returned word against a regenerated copy of the pattern, one byte lane at a time.

The memory side is a plain request/acknowledge port that allows one transfer in flight. The engine raises a one-cycle request and then waits for the acknowledge. A read acknowledge carries the read data. When the run ends the engine reports done, a pass flag, a sticky per-lane mismatch mask and an error code. A memory that stops answering is reported as a timeout.

Top module: `memtest_engine`

## Requirements
- R1: A one-cycle `start` while idle latches all configuration inputs, clears `done`, `err_code` and `lane_err`, and raises `busy` on the next cycle. `busy` stays high until the run ends, and falls in the same cycle that `done` rises. A `start` pulse while `busy` is high is ignored, and so are changes to the configuration inputs.
- R2: Each transfer is a single-cycle `mem_req`, with `mem_we` set to 1 for a write and 0 for a read. The next request comes only after `mem_ack` for the previous one. All N writes are issued before any of the N reads. No request is made while the block is idle.
- R3: The transfer count N is the smaller of the requested count and the region size 2^S. S is `size_log2` clamped to AW. A requested count of 0 selects the parameter DEFAULT_XFERS, which defaults to 0x20000.
- R4: Address ordering 0 is sequential: transfer i uses address (base + i) mod 2^AW. The read phase uses the same address order as the write phase.
- R5: Address ordering 1 is scrambled: transfer i uses index (i*PERM_MUL + PERM_ADD) mod 2^S, with defaults 2653 and 935, and the address is (base + index) mod 2^AW. Every address of the region is visited exactly once when N = 2^S.
- R6: The fixed data patterns, where i is the transfer number within a phase:
  - code 0 is counting: the word equals i.
  - code 1 is walking one: only bit (i mod DW) is set.
  - code 4 is all ones for even i and all zeros for odd i.
  - code 5 is 0x55 in every byte for even i and 0xAA for odd i.
  - code 6 is the latched `user_data`.
  - codes 9 to 15 behave as code 0.
- R7: The pseudo-random patterns, codes 2 (32-bit), 7 (16-bit) and 8 (8-bit), use a right-shifting Galois LFSR:
  - Each step shifts the state right and, if the old bit 0 was 1, XORs it with 0x80200003, 0xB400 or 0xB8 respectively.
  - The seeds are 0xACE12D7F, 0xACE1 and 0xE1.
  - Data bit b equals state bit (b mod width).
  - The state advances after every transfer, and the read phase restarts from the same seed.
- R8: Code 3 uses the 32-bit generator of R7, but its seed is the generator state reached at the end of the previous code-3 write phase. After reset that seed is 0xACE12D7F. Consecutive code-3 runs therefore write different data.
- R9: Lane k is bits [8k+7:8k] of the data word. `lane_err[k]` is set when any read word differs from the expected word in lane k. The mask is sticky for the whole run.
- R10: `pass` is high only while `done` is high, `err_code` is 0 and `lane_err` is all zero.
- R11: If no `mem_ack` arrives within TIMEOUT cycles after a request, the run aborts. `err_code` becomes 2'b10 and `done` rises TIMEOUT+1 cycles after the request cycle. `err_code` is never 2'b01 or 2'b11.
- R12: After reset the outputs `busy`, `done`, `pass`, `mem_req`, `lane_err` and `err_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request |
| pat_sel | input | 4 | Data pattern code |
| addr_rand | input | 1 | Address ordering: 0 sequential, 1 scrambled |
| size_log2 | input | 5 | Region size exponent in words |
| base_addr | input | AW | First address of the region |
| xfer_count | input | CW | Requested transfers per phase, 0 selects the default |
| user_data | input | DW | Word used by pattern code 6 |
| mem_req | output | 1 | Transfer request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Transfer completed |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Run finished cleanly |
| lane_err | output | LANES | Sticky per-lane mismatch mask |
| err_code | output | 2 | 0 none, 2 timeout |

## Verification
The bench runs every data pattern code, including a reserved one, and predicts each write word from the pattern rules. This separates the generators, the seeds and their widths. Two back-to-back code-3 runs show whether the seed is carried over rather than reloaded. Sequential and scrambled orders are used with region sizes of 1, 16, 32, 64 and an over-range exponent, with a zero count, and with a start address near the top of memory; these expose errors in count clamping, address wrap and permutation. Corrupted read bytes in chosen lanes, including one corruption outside the tested region, check the lane mask. A memory that stops acknowledging checks the abort path and its exact latency.

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int LANES = 5,
  parameter int LANE_W = 8,
  parameter int AW = 12,
  parameter int CW = 20,
  parameter int DEFAULT_XFERS = 'h20000,
  parameter int TIMEOUT = 64,
  parameter int PERM_MUL = 2653,
  parameter int PERM_ADD = 935
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [3:0]              pat_sel,
  input  logic                    addr_rand,
  input  logic [4:0]              size_log2,
  input  logic [AW-1:0]           base_addr,
  input  logic [CW-1:0]           xfer_count,
  input  logic [LANES*LANE_W-1:0] user_data,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [LANES*LANE_W-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [LANES*LANE_W-1:0] mem_rdata,
  output logic                    busy,
  output logic                    done,
  output logic                    pass,
  output logic [LANES-1:0]        lane_err,
  output logic [1:0]              err_code
);
  localparam int DW = LANES * LANE_W;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [31:0] SEED32 = 32'hACE1_2D7F;
  localparam logic [15:0] SEED16 = 16'hACE1;
  localparam logic [7:0]  SEED8  = 8'hE1;

  typedef enum logic [2:0] {S_IDLE, S_WREQ, S_WWAIT, S_RREQ, S_RWAIT} st_t;
  st_t state;

  logic [3:0]    cfg_pat;
  logic          cfg_rand;
  logic [AW-1:0] cfg_mask, cfg_base, pidx;
  logic [DW-1:0] cfg_user, walk, pat;
  logic [CW-1:0] total, idx;
  logic [31:0]   lfsr, seed, chain, lfsr_nx, seed_sel;
  logic [31:0]   region, want, n_xfer;
  logic [4:0]    sz;
  logic [TW-1:0] tmo;
  logic [LANES-1:0] lane_hit;
  logic          last;

  assign sz       = (size_log2 > 5'(AW)) ? 5'(AW) : size_log2;
  assign region   = 32'd1 << sz;
  assign want     = (xfer_count == '0) ? 32'(DEFAULT_XFERS) : 32'(xfer_count);
  assign n_xfer   = (want < region) ? want : region;
  assign seed_sel = (pat_sel == 4'd3) ? chain :
                    (pat_sel == 4'd7) ? {16'h0, SEED16} :
                    (pat_sel == 4'd8) ? {24'h0, SEED8} : SEED32;

  always_comb begin
    case (cfg_pat)
      4'd7:    lfsr_nx = {16'h0, lfsr[0] ? (lfsr[15:0] >> 1) ^ 16'hB400 : lfsr[15:0] >> 1};
      4'd8:    lfsr_nx = {24'h0, lfsr[0] ? (lfsr[7:0] >> 1) ^ 8'hB8 : lfsr[7:0] >> 1};
      default: lfsr_nx = lfsr[0] ? (lfsr >> 1) ^ 32'h8020_0003 : lfsr >> 1;
    endcase
  end

  always_comb begin
    pat = DW'(idx);
    case (cfg_pat)
      4'd1: pat = walk;
      4'd2, 4'd3: for (int b = 0; b < DW; b++) pat[b] = lfsr[b % 32];
      4'd7: for (int b = 0; b < DW; b++) pat[b] = lfsr[b % 16];
      4'd8: for (int b = 0; b < DW; b++) pat[b] = lfsr[b % 8];
      4'd4: pat = {DW{~idx[0]}};
      4'd5: for (int b = 0; b < DW; b++) pat[b] = ((b % 2) == 0) ^ idx[0];
      4'd6: pat = cfg_user;
      default: ;
    endcase
  end

  always_comb
    for (int k = 0; k < LANES; k++)
      lane_hit[k] = |(mem_rdata[k*LANE_W +: LANE_W] ^ pat[k*LANE_W +: LANE_W]);

  assign pidx      = cfg_rand ? idx[AW-1:0] * AW'(PERM_MUL) + AW'(PERM_ADD) : idx[AW-1:0];
  assign mem_addr  = cfg_base + (pidx & cfg_mask);
  assign mem_wdata = pat;
  assign mem_req   = (state == S_WREQ) || (state == S_RREQ);
  assign mem_we    = (state == S_WREQ);
  assign busy      = (state != S_IDLE);
  assign pass      = done && (lane_err == '0) && (err_code == 2'b00);
  assign last      = (idx == total - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cfg_pat <= '0; cfg_rand <= 1'b0; cfg_mask <= '0; cfg_base <= '0; cfg_user <= '0;
      total <= '0; idx <= '0; lfsr <= '0; seed <= '0; chain <= SEED32;
      walk <= '0; tmo <= '0; done <= 1'b0; lane_err <= '0; err_code <= 2'b00;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cfg_pat  <= pat_sel;
          cfg_rand <= addr_rand;
          cfg_mask <= AW'(region - 32'd1);
          cfg_base <= base_addr;
          cfg_user <= user_data;
          total    <= CW'(n_xfer);
          idx      <= '0;
          lfsr     <= seed_sel;
          seed     <= seed_sel;
          walk     <= DW'(1);
          done     <= 1'b0;
          lane_err <= '0;
          err_code <= 2'b00;
          state    <= S_WREQ;
        end
        S_WREQ: begin tmo <= '0; state <= S_WWAIT; end
        S_RREQ: begin tmo <= '0; state <= S_RWAIT; end
        S_WWAIT, S_RWAIT: begin
          if (mem_ack) begin
            lfsr <= lfsr_nx;
            walk <= {walk[DW-2:0], walk[DW-1]};
            idx  <= idx + CW'(1);
            if (state == S_RWAIT) lane_err <= lane_err | lane_hit;
            if (!last) state <= (state == S_WWAIT) ? S_WREQ : S_RREQ;
            else if (state == S_WWAIT) begin
              idx   <= '0;
              lfsr  <= seed;
              walk  <= DW'(1);
              if (cfg_pat == 4'd3) chain <= lfsr_nx;
              state <= S_RREQ;
            end else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end else if (tmo == TW'(TIMEOUT - 1)) begin
            err_code <= 2'b10;
            done     <= 1'b1;
            state    <= S_IDLE;
          end else tmo <= tmo + TW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/memtest_engine_chk.sv
module memtest_engine_chk #(
  parameter int LANES = 5
)(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             mem_req,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic [LANES-1:0] lane_err,
  input logic [1:0]       err_code
);
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  assert_done_ends_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  assert_req_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_mask_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((lane_err & $past(lane_err)) == $past(lane_err)));

  assert_pass_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && !busy && lane_err == '0));

  assert_err_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'b01) && (err_code != 2'b11));
endmodule

bind memtest_engine memtest_engine_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .busy(busy),
  .done(done), .pass(pass), .lane_err(lane_err), .err_code(err_code)
);

// File: tb/memtest_engine_tb_top.sv
module memtest_engine_tb_top;
  localparam int LANES = 5, LW = 8, AW = 12, CW = 20, DEFX = 37, TMO = 64;
  localparam int DW = LANES * LW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] pat_sel = '0;
  logic addr_rand = 1'b0;
  logic [4:0] size_log2 = '0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] xfer_count = '0;
  logic [DW-1:0] user_data = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic busy, done, pass;
  logic [LANES-1:0] lane_err;
  logic [1:0] err_code;

  always #2 clk = ~clk;

  memtest_engine #(.LANES(LANES), .LANE_W(LW), .AW(AW), .CW(CW),
                   .DEFAULT_XFERS(DEFX), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel), .addr_rand(addr_rand),
    .size_log2(size_log2), .base_addr(base_addr), .xfer_count(xfer_count),
    .user_data(user_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .pass(pass), .lane_err(lane_err), .err_code(err_code));

  logic [DW-1:0] mem [int];
  logic [DW-1:0] flip [int];
  logic [AW-1:0] q_addr [$];
  bit            q_we [$];
  logic [DW-1:0] q_data [$];
  int            obs_waddr [$];
  int vectors = 0, miscompares = 0, cyc = 0, ack_cnt = 0, req_num = 0, drop_req = -1, drop_cyc = 0;
  logic [DW-1:0] pending = '0;
  logic [31:0] chain = 32'hACE1_2D7F;
  string data_tag = "R6";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      chk(1'b0, "WD", "watchdog expired", 64'(cyc), 64'd0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // memory model and request comparison against the predicted stream
  always @(negedge clk) begin
    logic [AW-1:0] ea;
    bit ew;
    logic [DW-1:0] ed, f;
    mem_ack = 1'b0;
    if (rst_n) begin
      if (ack_cnt > 0) begin
        ack_cnt--;
        if (ack_cnt == 0) begin mem_ack = 1'b1; mem_rdata = pending; end
      end
      if (mem_req) begin
        chk(busy, "R2", "request while idle", 64'(busy), 64'd1);
        if (q_addr.size() == 0) chk(1'b0, "R2", "unexpected request", 64'(mem_addr), 64'd0);
        else begin
          ea = q_addr.pop_front(); ew = q_we.pop_front(); ed = q_data.pop_front();
          chk(mem_addr == ea, "R4", "request address", 64'(mem_addr), 64'(ea));
          chk(mem_we == ew, "R2", "request direction", 64'(mem_we), 64'(ew));
          if (ew) chk(mem_wdata == ed, data_tag, "write data", 64'(mem_wdata), 64'(ed));
        end
        if (mem_we) begin
          mem[int'(mem_addr)] = mem_wdata;
          obs_waddr.push_back(int'(mem_addr));
        end else begin
          f = flip.exists(int'(mem_addr)) ? flip[int'(mem_addr)] : '0;
          pending = (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0) ^ f;
        end
        if (req_num == drop_req) drop_cyc = cyc;
        else ack_cnt = 1 + (req_num % 3);
        req_num++;
      end
    end
  end

  function automatic logic [31:0] step(int m, logic [31:0] s);
    logic [15:0] a;
    logic [7:0] b;
    if (m == 7) begin a = s[15:0]; a = a[0] ? (a >> 1) ^ 16'hB400 : a >> 1; return {16'h0, a}; end
    if (m == 8) begin b = s[7:0]; b = b[0] ? (b >> 1) ^ 8'hB8 : b >> 1; return {24'h0, b}; end
    return s[0] ? (s >> 1) ^ 32'h8020_0003 : s >> 1;
  endfunction

  function automatic logic [DW-1:0] pval(int m, int i, logic [31:0] s, logic [DW-1:0] u);
    logic [DW-1:0] d;
    d = '0;
    case (m)
      1: d[i % DW] = 1'b1;
      2, 3: for (int b = 0; b < DW; b++) d[b] = s[b % 32];
      7: for (int b = 0; b < DW; b++) d[b] = s[b % 16];
      8: for (int b = 0; b < DW; b++) d[b] = s[b % 8];
      4: d = (i % 2 == 0) ? '1 : '0;
      5: for (int b = 0; b < DW; b++) d[b] = ((b % 2) == (i % 2));
      6: d = u;
      default: d = DW'(i);
    endcase
    return d;
  endfunction

  task automatic run(input int m, input bit rnd, input int sz, input int base, input int cnt,
                     input logic [DW-1:0] u, input int drop, input bit poke, input string tag);
    int szc, region, n, distinct;
    logic [31:0] s;
    logic [DW-1:0] dl [$];
    logic [AW-1:0] al [$];
    logic [LANES-1:0] emask;
    logic [DW-1:0] f;
    bit seen [int];
    szc = (sz > AW) ? AW : sz;
    region = 1 << szc;
    n = (cnt == 0) ? DEFX : cnt;
    if (n > region) n = region;
    s = (m == 3) ? chain : (m == 7) ? 32'h0000_ACE1 : (m == 8) ? 32'h0000_00E1 : 32'hACE1_2D7F;
    for (int i = 0; i < n; i++) begin
      int ix;
      ix = rnd ? ((i * 2653 + 935) % region) : (i % region);
      al.push_back(AW'(base + ix));
      dl.push_back(pval(m, i, s, u));
      s = step(m, s);
    end
    if (m == 3 && (drop < 0 || drop >= n)) chain = s;
    emask = '0;
    for (int i = 0; i < n; i++) begin
      q_addr.push_back(al[i]); q_we.push_back(1'b1); q_data.push_back(dl[i]);
    end
    for (int i = 0; i < n; i++) begin
      q_addr.push_back(al[i]); q_we.push_back(1'b0); q_data.push_back(dl[i]);
      f = flip.exists(int'(al[i])) ? flip[int'(al[i])] : '0;
      for (int k = 0; k < LANES; k++) if (|f[k*LW +: LW]) emask[k] = 1'b1;
    end
    @(negedge clk);
    data_tag = tag;
    pat_sel = 4'(m); addr_rand = rnd; size_log2 = 5'(sz); base_addr = AW'(base);
    xfer_count = CW'(cnt); user_data = u;
    req_num = 0; drop_req = drop; obs_waddr.delete();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R1", "busy after start", 64'({busy, done}), 64'd2);
    if (poke) begin
      repeat (10) @(negedge clk);
      pat_sel = 4'd6; base_addr = ~base_addr; xfer_count = CW'(1); addr_rand = ~addr_rand;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(!busy, "R1", "busy low at done", 64'(busy), 64'd0);
    if (drop >= 0 && drop < 2 * n) begin
      chk(err_code == 2'b10, "R11", "timeout code", 64'(err_code), 64'd2);
      chk(cyc - drop_cyc == TMO + 1, "R11", "abort latency", 64'(cyc - drop_cyc), 64'(TMO + 1));
      chk(!pass, "R11", "pass after timeout", 64'(pass), 64'd0);
      chk(req_num == drop + 1, "R11", "requests before abort", 64'(req_num), 64'(drop + 1));
      q_addr.delete(); q_we.delete(); q_data.delete();
    end else begin
      chk(err_code == 2'b00, "R11", "no error code", 64'(err_code), 64'd0);
      chk(lane_err == emask, "R9", "lane mask", 64'(lane_err), 64'(emask));
      chk(pass == (emask == '0), "R10", "pass flag", 64'(pass), 64'(emask == '0));
      chk(req_num == 2 * n, poke ? "R1" : "R3", "request count", 64'(req_num), 64'(2 * n));
      chk(q_addr.size() == 0, "R3", "missing requests", 64'(q_addr.size()), 64'd0);
      if (rnd) begin
        foreach (obs_waddr[j]) seen[obs_waddr[j]] = 1'b1;
        distinct = seen.num();
        chk(distinct == n, "R5", "distinct addresses", 64'(distinct), 64'(n));
      end
    end
    flip.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, pass, mem_req, lane_err, err_code} == '0, "R12", "reset outputs",
        64'({busy, done, pass, mem_req, lane_err, err_code}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, pass, mem_req} == '0, "R12", "idle after reset", 64'({busy, done, pass, mem_req}), 64'd0);
    run(0, 0, 4, 100, 16, '0, -1, 0, "R6");
    run(1, 0, 6, 0, 50, '0, -1, 0, "R6");
    run(2, 0, 5, 300, 32, '0, -1, 0, "R7");
    run(7, 0, 5, 40, 20, '0, -1, 0, "R7");
    run(8, 0, 5, 80, 20, '0, -1, 0, "R7");
    run(4, 0, 3, 7, 8, '0, -1, 0, "R6");
    run(5, 0, 3, 9, 8, '0, -1, 0, "R6");
    run(5, 0, 0, 11, 8, '0, -1, 0, "R6");
    run(6, 0, 2, 20, 4, 40'h12_3456_789A, -1, 0, "R6");
    run(12, 0, 3, 30, 6, '0, -1, 0, "R6");
    run(3, 0, 4, 500, 10, '0, -1, 0, "R8");
    run(3, 0, 4, 500, 10, '0, -1, 0, "R8");
    run(0, 1, 6, 4090, 0, '0, -1, 0, "R6");
    run(2, 1, 5, 1000, 100, '0, -1, 0, "R7");
    run(0, 1, 31, 0, 9, '0, -1, 0, "R6");
    flip[203] = 40'h00_0100_0000;
    flip[900] = 40'hFF_FFFF_FFFF;
    run(2, 0, 4, 200, 16, '0, -1, 0, "R7");
    flip[201] = 40'h00_0000_0080;
    flip[214] = 40'h01_0000_0000;
    run(0, 0, 4, 200, 16, '0, -1, 0, "R6");
    run(2, 0, 4, 200, 16, '0, -1, 0, "R7");
    run(0, 0, 4, 600, 16, '0, 5, 0, "R6");
    run(7, 0, 5, 700, 30, '0, -1, 1, "R7");
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule